// File: doc/BRIEF.md
# Power Management Event and SCI Controller

This block is the event core of a power management function on a south bridge. It holds an event status register, a matching enable register and a control register. It also runs a free-running power management timer. Three external event inputs report a power button press, a real-time clock alarm and a global lock release. Each of these sets a status bit. The timer sets its own status bit when its most significant bit changes. A status bit together with its enable bit drives a level-sensitive system control interrupt (SCI).

Software reaches these registers through a 64-byte I/O window that can be moved. A configuration write port sets the window's base address and turns decoding on or off. The configuration space also holds a small SMBus base field and one fixed-reset byte, and both read back through the configuration read port.

Top module: `pm_event_core`

## Requirements
- R1: After reset the event status, event enable and control registers are zero, window decoding is off (configuration byte 0x80 reads 0x00), `sci` is low, configuration byte 0x90 reads 0x01 and configuration byte 0xD2 reads 0x90.
- R2: Event status bit positions are: timer 0, global lock 5, power button 8, RTC alarm 10. A one-cycle pulse on `evt_glbl`, `evt_pwrbtn` or `evt_rtc` sets the matching bit at the next clock edge. Status bits at all other positions read 0.
- R3: Writing a 1 to a bit of the status register (window offset 0x00) clears that bit. Writing a 0 leaves the bit unchanged.
- R4: `sci` is high whenever, at any of the positions 0, 5, 8 or 10, both the status bit and the enable bit (window offset 0x02) are set. It follows the registers with no extra delay.
- R5: Enable bits at any other position have no effect on `sci`.
- R6: The timer counts up by one on each cycle with `tmr_tick` high. It reads zero-extended at window offset 0x08. Writes to that offset are ignored.
- R7: The timer status bit is set when the timer's most significant bit toggles, but only while timer enable (enable bit 0) is set and timer status is clear.
- R8: The window base is configuration bytes 0x41:0x40 masked with 0xFFC0. An access hits when `io_addr[15:6]` matches the base. The control register sits at offset 0x04. Reads outside the window or at unused offsets return 0.
- R9: The window decodes only while bit 0 of configuration byte 0x80 is set. While it is clear, I/O writes are ignored, reads return 0 and `io_hit` is low.
- R10: Bit 0 of configuration byte 0x90 always reads 1, whatever value is written. Byte 0xD2 is writable.
- R11: When an event pulse and a write-1-to-clear of the same status bit fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 32 | I/O read data (combinational) |
| io_hit | output | 1 | Address falls inside the enabled window |
| tmr_tick | input | 1 | Timer count enable pulse |
| evt_pwrbtn | input | 1 | Power button event pulse |
| evt_rtc | input | 1 | RTC alarm event pulse |
| evt_glbl | input | 1 | Global lock event pulse |
| sci | output | 1 | System control interrupt, level |

## Verification
Every register update lands on the first clock edge after a write, an event pulse or a tick. Reads through `io_rdata` and `cfg_rdata` are combinational and so is `sci`, so each result is due one edge after its stimulus. The bench drives inputs on the falling edge. It lets one rising edge pass and samples shortly after that edge, so the value it checks comes from exactly that one edge. Timer checks count the ticks applied, so the expected timer value and the cycle in which the status bit sets follow from that count.

// File: rtl/pm_event_core.sv
module pm_event_core #(
  parameter int TMR_W    = 24,
  parameter int WIN_BITS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [15:0] io_wdata,
  output logic [31:0] io_rdata,
  output logic        io_hit,
  input  logic        tmr_tick,
  input  logic        evt_pwrbtn,
  input  logic        evt_rtc,
  input  logic        evt_glbl,
  output logic        sci
);

  localparam int B_TMR = 0;
  localparam int B_GBL = 5;
  localparam int B_PWR = 8;
  localparam int B_RTC = 10;
  localparam logic [15:0] EVT_MASK  = (16'd1 << B_TMR) | (16'd1 << B_GBL) |
                                      (16'd1 << B_PWR) | (16'd1 << B_RTC);
  localparam logic [15:0] BASE_MASK = 16'hFFFF << WIN_BITS;
  localparam logic [WIN_BITS-1:0] OFF_STS = 'h0;
  localparam logic [WIN_BITS-1:0] OFF_EN  = 'h2;
  localparam logic [WIN_BITS-1:0] OFF_CTL = 'h4;
  localparam logic [WIN_BITS-1:0] OFF_TMR = 'h8;

  logic [7:0] base_b0, base_b1, base_b2, base_b3;
  logic [7:0] win_ctl, smb_lo, smb_hi, misc_d2;
  logic [15:0] sts_q, en_q, ctl_q;
  logic [TMR_W-1:0] tmr_q;

  // configuration space
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_b0 <= 8'h00;
      base_b1 <= 8'h00;
      base_b2 <= 8'h00;
      base_b3 <= 8'h00;
      win_ctl <= 8'h00;
      smb_lo  <= 8'h01;
      smb_hi  <= 8'h00;
      misc_d2 <= 8'h90;
    end else if (cfg_we) begin
      case (cfg_addr)
        8'h40: base_b0 <= cfg_wdata;
        8'h41: base_b1 <= cfg_wdata;
        8'h42: base_b2 <= cfg_wdata;
        8'h43: base_b3 <= cfg_wdata;
        8'h80: win_ctl <= cfg_wdata;
        8'h90: smb_lo  <= cfg_wdata | 8'h01;
        8'h91: smb_hi  <= cfg_wdata;
        8'hD2: misc_d2 <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_addr)
      8'h40:   cfg_rdata = base_b0;
      8'h41:   cfg_rdata = base_b1;
      8'h42:   cfg_rdata = base_b2;
      8'h43:   cfg_rdata = base_b3;
      8'h80:   cfg_rdata = win_ctl;
      8'h90:   cfg_rdata = smb_lo;
      8'h91:   cfg_rdata = smb_hi;
      8'hD2:   cfg_rdata = misc_d2;
      default: cfg_rdata = 8'h00;
    endcase
  end

  // window decode
  wire [15:0] win_base = {base_b1, base_b0} & BASE_MASK;
  wire [WIN_BITS-1:0] off = io_addr[WIN_BITS-1:0];
  assign io_hit = win_ctl[0] && (io_addr[15:WIN_BITS] == win_base[15:WIN_BITS]);

  wire wr_sts = io_wr && io_hit && (off == OFF_STS);
  wire wr_en  = io_wr && io_hit && (off == OFF_EN);
  wire wr_ctl = io_wr && io_hit && (off == OFF_CTL);

  // timer and overflow arming
  wire tmr_msb_flip = tmr_tick && (&tmr_q[TMR_W-2:0]);
  wire tmr_armed    = en_q[B_TMR] && !sts_q[B_TMR];

  logic [15:0] set_vec;
  always_comb begin
    set_vec        = 16'h0000;
    set_vec[B_TMR] = tmr_msb_flip && tmr_armed;
    set_vec[B_GBL] = evt_glbl;
    set_vec[B_PWR] = evt_pwrbtn;
    set_vec[B_RTC] = evt_rtc;
  end

  wire [16:0] clr_vec = {1'b0, wr_sts ? io_wdata : 16'h0000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= 16'h0000;
      en_q  <= 16'h0000;
      ctl_q <= 16'h0000;
      tmr_q <= '0;
    end else begin
      sts_q <= ((sts_q & ~clr_vec[15:0]) | set_vec) & EVT_MASK;
      if (wr_en)    en_q  <= io_wdata;
      if (wr_ctl)   ctl_q <= io_wdata;
      if (tmr_tick) tmr_q <= tmr_q + 1'b1;
    end
  end

  assign sci = |(sts_q & en_q & EVT_MASK);

  always_comb begin
    io_rdata = 32'h0;
    if (io_hit) begin
      case (off)
        OFF_STS: io_rdata = {16'h0, sts_q};
        OFF_EN:  io_rdata = {16'h0, en_q};
        OFF_CTL: io_rdata = {16'h0, ctl_q};
        OFF_TMR: io_rdata = 32'(tmr_q);
        default: io_rdata = 32'h0;
      endcase
    end
  end

  p_pwr_sci_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pwrbtn && en_q[B_PWR] && !wr_en) |=> sci);

  p_w1c_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_q[B_PWR]) |-> $past(wr_sts && io_wdata[B_PWR]));

  p_tmr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_tick |=> $stable(tmr_q));

  p_tmr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_tick |=> (tmr_q == $past(tmr_q) + 1'b1));

  p_tsts_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[B_TMR]) |-> $past(en_q[B_TMR]));

  p_win_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !win_ctl[0] |-> (!io_hit && io_rdata == 32'h0));

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rtc |=> sts_q[B_RTC]);

endmodule

// File: tb/pm_event_core_tb_top.sv
module pm_event_core_tb_top;
  localparam int TW = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [7:0] cfg_addr = 0, cfg_wdata = 0; logic [7:0] cfg_rdata;
  logic io_wr = 0; logic [15:0] io_addr = 0, io_wdata = 0; logic [31:0] io_rdata;
  logic io_hit, tmr_tick = 0, evt_pwrbtn = 0, evt_rtc = 0, evt_glbl = 0, sci;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  pm_event_core #(.TMR_W(TW)) dut_i (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .io_wr, .io_addr, .io_wdata, .io_rdata, .io_hit, .tmr_tick,
    .evt_pwrbtn, .evt_rtc, .evt_glbl, .sci);

  localparam int NV = 30;
  // ops: 0 cfg write, 1 cfg read check, 2 io write, 3 io read check, 4 event pulse {glbl,pwr,rtc}, 5 sci check
  localparam logic [2:0]  V_OP [NV] = '{1,1,1,5, 0,0,2,0,3, 2,3,4,3,5, 2,3,2,5, 4,3,5, 2,5,2,5, 2,3,3,2,3};
  localparam logic [15:0] V_AD [NV] = '{16'h90,16'hD2,16'h80,0, 16'h40,16'h41,16'hB002,16'h80,16'hB002,
    16'hB002,16'hB002,0,16'hB000,0, 16'hB000,16'hB000,16'hB000,0, 0,16'hB000,0,
    16'hB002,0,16'hB002,0, 16'hB004,16'hB004,16'hB040,16'hB008,16'hB008};
  localparam logic [15:0] V_DT [NV] = '{16'h01,16'h90,16'h00,0, 16'h3F,16'hB0,16'hFFFF,16'h01,16'h0000,
    16'h0100,16'h0100,16'h2,16'h0100,1, 16'h0000,16'h0100,16'h0100,0, 16'h5,16'h0420,0,
    16'hFADE,0,16'h0020,1, 16'h1234,16'h1234,16'h0000,16'h00FF,16'h0000};
  // requirement tags per vector: R1 R10 R9 R4 R8 R2 R3 R5 R6
  localparam logic [3:0]  V_RQ [NV] = '{1,10,1,1, 8,8,9,9,9, 8,8,2,2,4, 3,3,3,4, 2,2,5, 5,5,4,4, 8,8,8,6,6};

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_addr = a; cfg_wdata = d; cfg_we = 1;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); io_addr = a; #1 d = io_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tmr_tick = 1;
    end
    @(negedge clk); tmr_tick = 0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int v = 0; v < NV; v++) begin
      tag = $sformatf("R%0d", V_RQ[v]);
      case (V_OP[v])
        3'd0: cfg_write(V_AD[v][7:0], V_DT[v][7:0]);
        3'd1: begin @(negedge clk); cfg_addr = V_AD[v][7:0]; #1 chk(tag, {24'h0, cfg_rdata}, {16'h0, V_DT[v]}); end
        3'd2: io_write(V_AD[v], V_DT[v]);
        3'd3: begin io_read(V_AD[v], rd); chk(tag, rd, {16'h0, V_DT[v]}); end
        3'd4: begin
          @(negedge clk); {evt_glbl, evt_pwrbtn, evt_rtc} = V_DT[v][2:0];
          @(negedge clk); {evt_glbl, evt_pwrbtn, evt_rtc} = 3'b000;
        end
        default: begin @(negedge clk); #1 chk(tag, {31'h0, sci}, {16'h0, V_DT[v]}); end
      endcase
    end

    // R9: io_hit low outside window, high inside
    @(negedge clk); io_addr = 16'hB03E; #1 chk("R9", {31'h0, io_hit}, 1);
    // R10: bit 0 of byte 0x90 forced to 1
    cfg_write(8'h90, 8'hE0);
    @(negedge clk); cfg_addr = 8'h90; #1 chk("R10", {24'h0, cfg_rdata}, 32'hE1);
    cfg_write(8'hD2, 8'h5A);
    @(negedge clk); cfg_addr = 8'hD2; #1 chk("R10", {24'h0, cfg_rdata}, 32'h5A);

    // R11: event and clear of the same bit in one cycle
    io_write(16'hB000, 16'h0420);
    @(negedge clk); evt_pwrbtn = 1; io_addr = 16'hB000; io_wdata = 16'h0100; io_wr = 1;
    @(negedge clk); evt_pwrbtn = 0; io_wr = 0;
    io_read(16'hB000, rd); chk("R11", rd, 32'h0100);
    io_write(16'hB000, 16'h0100);

    // R6 / R7: timer counting and gated overflow
    ticks(100);
    io_read(16'hB008, rd); chk("R6", rd, 100);
    ticks(28);
    io_read(16'hB008, rd); chk("R6", rd, 128);
    io_read(16'hB000, rd); chk("R7", rd, 32'h0000);
    io_write(16'hB002, 16'h0001);
    ticks(127);
    io_read(16'hB000, rd); chk("R7", rd, 32'h0000);
    ticks(1);
    io_read(16'hB000, rd); chk("R7", rd, 32'h0001);
    @(negedge clk); #1 chk("R4", {31'h0, sci}, 1);
    io_read(16'hB008, rd); chk("R6", rd, 0);

    // R8: relocate the window
    cfg_write(8'h40, 8'h40); cfg_write(8'h41, 8'hC0);
    io_read(16'hB004, rd); chk("R8", rd, 0);
    io_read(16'hC044, rd); chk("R8", rd, 32'h1234);

    // R1: reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    #1 chk("R1", {31'h0, sci}, 0);
    cfg_addr = 8'h80; #1 chk("R1", {24'h0, cfg_rdata}, 0);
    cfg_addr = 8'h90; #1 chk("R1", {24'h0, cfg_rdata}, 32'h01);
    cfg_write(8'h80, 8'h01);
    io_read(16'h0000, rd); chk("R1", rd, 0);
    io_read(16'h0002, rd); chk("R1", rd, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule